// File: doc/BRIEF.md
# Bank State Tracker and Command Checker

This block watches the decoded command stream headed for a four-bank synchronous DRAM. It keeps its own copy of each bank's state: whether the bank is open, which row it holds, and whether an auto-precharge close is pending. It also keeps a global power state and the state of the data burst in flight. The controller reads the per-bank status and the open rows to plan its next command. A one-cycle error pulse flags any command that is illegal in the current state, and an illegal command changes nothing.

The block models timing only through simple cycle counters. These are the burst length, programmed through a mode load, and the auto-precharge close that follows a read or write burst. Power-down follows the clock-enable input. Self refresh is entered and left by explicit commands.

Top module: `bank_state_tracker`

## Requirements
- R1: After reset, all banks are closed, every open-row output is 0, `mode` is 0 (idle), `burst_busy` is 0, `cmd_err` is 0, and the burst length is 4 (two clock cycles).
- R2: Command code 1 (activate) to a closed bank sets that bank's `bank_open` bit at the next edge and stores `addr` as its row. A stored row does not change while the bank stays open. `mode` reads 1 (active) in the run state while any bank is open, and 0 otherwise.
- R3: A read (code 2) or write (code 3) to a closed bank, or an activate to an open bank, raises `cmd_err` for one cycle and changes no output.
- R4: Precharge (code 4) with `addr[10]`=0 closes only the bank selected by `ba`. With `addr[10]`=1 it closes every bank. Precharging a closed bank is legal and has no effect.
- R5: A read or write with `addr[10]`=1 closes its bank exactly half the burst length in cycles after the command edge. Until that close, any read, write or activate to that bank is an error.
- R6: A legal read or write holds `burst_busy` high for half the burst length in cycles. A new read or write restarts that count.
- R7: Burst stop (code 9) clears `burst_busy` at the next edge. It is an error when no burst is in flight, or when the burst in flight carries auto-precharge.
- R8: Auto refresh (code 5), self-refresh entry (code 6) and mode load (code 8) are legal only while all banks are closed. Otherwise they are errors.
- R9: A mode load with `ba`=0 sets the burst length from `addr[2:0]`: 1→2, 2→4, 3→8, 4→16. Any other code is an error. A mode load with `ba`=2 is legal and has no effect. With `ba`=1 or 3 it is an error.
- R10: In the run state, `cke` sampled low enters power-down. `mode` becomes 2 if no bank was open and 3 if any bank was open. `cke` sampled high in power-down returns to the run state.
- R11: Any command other than no-op (code 0) is an error and has no effect in three cases: while `cke` is low, while in power-down, and while in self refresh, where only self-refresh exit (code 7) is accepted. Self refresh shows `mode`=4, and exit returns to `mode` 0.
- R12: Codes 10 to 15 are errors, and self-refresh exit in the run state is an error. A no-op never raises `cmd_err`.
- R13: `cmd_err` is registered. It is high exactly in the cycle after the edge that sampled the illegal command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable level as seen by the device |
| cmd | input | 4 | Decoded command code |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, auto-precharge/all-bank bit 10, mode code bits [2:0] |
| bank_open | output | 4 | One bit per bank, 1 = open |
| open_row | output | 52 | Row per bank, bank i at bits [13*i +: 13] |
| mode | output | 3 | 0 idle, 1 active, 2 precharge power-down, 3 active power-down, 4 self refresh |
| burst_busy | output | 1 | A data burst is in flight |
| cmd_err | output | 1 | Illegal-command pulse |

## Verification
A behavioural model in the bench predicts every output on every clock. The bench first opens two banks, then tries reads and writes against open and closed banks, so that the legal and illegal bank checks are told apart. Plain bursts, overlapping bursts and stopped bursts are run at burst lengths 2, 4 and 8. These separate the burst counter from the auto-precharge counters, and the close must land on the exact cycle. Precharge is tried with both values of bit 10, and the global commands and power transitions are tried with banks open and with all banks closed. Together these show that the scope rules and the power-down kind depend on bank state, and that commands are refused when the clock enable is off.

// File: rtl/bst_pkg.sv
package bst_pkg;
  localparam int CNT_W = 4;

  typedef enum logic [3:0] {
    CMD_NOP   = 4'd0,
    CMD_ACT   = 4'd1,
    CMD_RD    = 4'd2,
    CMD_WR    = 4'd3,
    CMD_PRE   = 4'd4,
    CMD_REF   = 4'd5,
    CMD_SRIN  = 4'd6,
    CMD_SROUT = 4'd7,
    CMD_LMR   = 4'd8,
    CMD_BST   = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {PW_RUN, PW_PPD, PW_APD, PW_SR} pwr_e;

  typedef enum logic [2:0] {
    MS_IDLE   = 3'd0,
    MS_ACTIVE = 3'd1,
    MS_PRE_PD = 3'd2,
    MS_ACT_PD = 3'd3,
    MS_SELF   = 3'd4
  } mstate_e;

  // Clock cycles of a burst for a length code (two beats per cycle); 0 = reserved.
  function automatic logic [CNT_W-1:0] burst_cycles(input logic [2:0] code);
    case (code)
      3'd1:    burst_cycles = 4'd1;
      3'd2:    burst_cycles = 4'd2;
      3'd3:    burst_cycles = 4'd4;
      3'd4:    burst_cycles = 4'd8;
      default: burst_cycles = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/bst_cmd_check.sv
module bst_cmd_check
  import bst_pkg::*;
#(
  parameter int NB   = 4,
  parameter int BA_W = $clog2(NB)
) (
  input  cmd_e            op,
  input  logic [BA_W-1:0] ba,
  input  logic [2:0]      mcode,
  input  logic            cke,
  input  pwr_e            pwr,
  input  logic [NB-1:0]   open_vec,
  input  logic [NB-1:0]   ap_vec,
  input  logic            burst_live,
  input  logic            burst_ap,
  output logic            legal,
  output logic            illegal
);
  logic all_idle;
  assign all_idle = (open_vec == '0);

  always_comb begin
    legal = 1'b0;
    case (pwr)
      PW_SR:  legal = (op == CMD_NOP) || (op == CMD_SROUT);
      PW_RUN: begin
        if (!cke) legal = (op == CMD_NOP);
        else begin
          case (op)
            CMD_NOP:           legal = 1'b1;
            CMD_ACT:           legal = !open_vec[ba];
            CMD_RD, CMD_WR:    legal = open_vec[ba] && !ap_vec[ba];
            CMD_PRE:           legal = 1'b1;
            CMD_REF, CMD_SRIN: legal = all_idle;
            CMD_LMR:           legal = all_idle &&
                                       ((ba == BA_W'(0) && burst_cycles(mcode) != '0) ||
                                        ba == BA_W'(2));
            CMD_BST:           legal = burst_live && !burst_ap;
            default:           legal = 1'b0;
          endcase
        end
      end
      default: legal = (op == CMD_NOP);
    endcase
  end

  assign illegal = !legal && (op != CMD_NOP);
endmodule

// File: rtl/bst_bank_slot.sv
module bst_bank_slot #(
  parameter int ROW_W = 13,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_hit,
  input  logic             pre_hit,
  input  logic             ap_arm,
  input  logic [CNT_W-1:0] ap_len,
  input  logic [ROW_W-1:0] row_in,
  output logic             open_q,
  output logic [ROW_W-1:0] row_q,
  output logic             ap_busy
);
  logic [CNT_W-1:0] ap_cnt;
  logic             ap_done;

  assign ap_done = (ap_cnt == CNT_W'(1));
  assign ap_busy = (ap_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      ap_cnt <= '0;
    end else if (pre_hit) begin
      open_q <= 1'b0;
      ap_cnt <= '0;
    end else if (act_hit) begin
      open_q <= 1'b1;
      row_q  <= row_in;
    end else if (ap_arm) begin
      ap_cnt <= ap_len;
    end else if (ap_done) begin
      open_q <= 1'b0;
      ap_cnt <= '0;
    end else if (ap_busy) begin
      ap_cnt <= ap_cnt - CNT_W'(1);
    end
  end

  // R4/R5: a bank only closes by precharge or by its auto-precharge counter
  assert_close_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(open_q) |-> $past(pre_hit || ap_done));
  // R2: the row of an open bank stays put
  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(open_q) && open_q) |-> (row_q == $past(row_q)));
  // R5: auto-precharge is only armed on an open bank
  assert_arm_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ap_arm |-> open_q);
endmodule

// File: rtl/bst_pwr_ctl.sv
module bst_pwr_ctl
  import bst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             go_srin,
  input  logic             go_srout,
  input  logic             go_lmr,
  input  logic [2:0]       lmr_code,
  input  logic             go_rw,
  input  logic             rw_ap,
  input  logic             go_bst,
  input  logic             any_open,
  output pwr_e             pwr,
  output logic [CNT_W-1:0] half_len,
  output logic             burst_live,
  output logic             burst_ap
);
  logic [2:0]       bl_code;
  logic [CNT_W-1:0] bcnt;

  assign half_len   = burst_cycles(bl_code);
  assign burst_live = (bcnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr      <= PW_RUN;
      bl_code  <= 3'd2;
      bcnt     <= '0;
      burst_ap <= 1'b0;
    end else begin
      if (go_lmr) bl_code <= lmr_code;
      if (go_rw) begin
        bcnt     <= half_len;
        burst_ap <= rw_ap;
      end else if (go_bst) begin
        bcnt <= '0;
      end else if (burst_live) begin
        bcnt <= bcnt - CNT_W'(1);
      end
      case (pwr)
        PW_RUN: begin
          if (go_srin)   pwr <= PW_SR;
          else if (!cke) pwr <= any_open ? PW_APD : PW_PPD;
        end
        PW_SR:   if (go_srout) pwr <= PW_RUN;
        default: if (cke) pwr <= PW_RUN;
      endcase
    end
  end

  // R7: a burst stop leaves no burst in flight
  assert_bst_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(go_bst) |-> !burst_live);
  // R8: self refresh is entered only with every bank closed
  assert_sr_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr == PW_SR && $past(pwr) == PW_RUN) |-> !$past(any_open));
endmodule

// File: rtl/bank_state_tracker.sv
module bank_state_tracker
  import bst_pkg::*;
#(
  parameter int NB    = 4,
  parameter int ROW_W = 13,
  localparam int BA_W = $clog2(NB)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cke,
  input  logic [3:0]          cmd,
  input  logic [BA_W-1:0]     ba,
  input  logic [ROW_W-1:0]    addr,
  output logic [NB-1:0]       bank_open,
  output logic [NB*ROW_W-1:0] open_row,
  output logic [2:0]          mode,
  output logic                burst_busy,
  output logic                cmd_err
);
  cmd_e             op;
  pwr_e             pwr;
  logic             legal, illegal, a10, is_rw;
  logic [NB-1:0]    ap_vec;
  logic [CNT_W-1:0] half_len;
  logic             burst_ap;

  assign op    = cmd_e'(cmd);
  assign a10   = addr[10];
  assign is_rw = (op == CMD_RD) || (op == CMD_WR);

  bst_cmd_check #(.NB(NB)) u_chk (
    .op(op), .ba(ba), .mcode(addr[2:0]), .cke(cke), .pwr(pwr),
    .open_vec(bank_open), .ap_vec(ap_vec), .burst_live(burst_busy),
    .burst_ap(burst_ap), .legal(legal), .illegal(illegal)
  );

  bst_pwr_ctl u_pwr (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .go_srin(legal && op == CMD_SRIN),
    .go_srout(legal && op == CMD_SROUT),
    .go_lmr(legal && op == CMD_LMR && ba == BA_W'(0)),
    .lmr_code(addr[2:0]),
    .go_rw(legal && is_rw), .rw_ap(a10),
    .go_bst(legal && op == CMD_BST),
    .any_open(|bank_open),
    .pwr(pwr), .half_len(half_len), .burst_live(burst_busy), .burst_ap(burst_ap)
  );

  for (genvar i = 0; i < NB; i++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(i));
    bst_bank_slot #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .act_hit(legal && op == CMD_ACT && hit),
      .pre_hit(legal && op == CMD_PRE && (a10 || hit)),
      .ap_arm(legal && is_rw && a10 && hit),
      .ap_len(half_len), .row_in(addr),
      .open_q(bank_open[i]), .row_q(open_row[i*ROW_W +: ROW_W]),
      .ap_busy(ap_vec[i])
    );
  end

  always_comb begin
    case (pwr)
      PW_RUN:  mode = (|bank_open) ? MS_ACTIVE : MS_IDLE;
      PW_PPD:  mode = MS_PRE_PD;
      PW_APD:  mode = MS_ACT_PD;
      default: mode = MS_SELF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_err <= 1'b0;
    else        cmd_err <= illegal;
  end

  // R12: an error pulse always follows a non-no-op command
  assert_err_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> ($past(cmd) != 4'd0));
  // R8: self refresh never coexists with an open bank
  assert_sr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> (bank_open == '0));
  // R11: no bank opens while powered down
  assert_pd_no_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pwr) != PW_RUN && pwr != PW_RUN) |-> ((bank_open & ~$past(bank_open)) == '0));
endmodule

// File: tb/sim_bank_state_tracker.sv
module sim_bank_state_tracker;
  localparam int NB = 4;
  localparam int RW = 13;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, cke, burst_busy, cmd_err;
  logic [3:0] cmd;
  logic [1:0] ba;
  logic [RW-1:0] addr;
  logic [NB-1:0] bank_open;
  logic [NB*RW-1:0] open_row;
  logic [2:0] mode;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  int m_open[NB], m_row[NB], m_apc[NB];
  int m_pwr;   // 0 run, 1 precharge pd, 2 active pd, 3 self refresh
  int m_half, m_bcnt, m_bap, m_err;

  bank_state_tracker u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .ba(ba), .addr(addr),
    .bank_open(bank_open), .open_row(open_row), .mode(mode),
    .burst_busy(burst_busy), .cmd_err(cmd_err)
  );

  function automatic int half_of(input int code);
    if (code >= 1 && code <= 4) return 1 << (code - 1);
    return 0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin m_open[i] = 0; m_row[i] = 0; m_apc[i] = 0; end
    m_pwr = 0; m_half = 2; m_bcnt = 0; m_bap = 0; m_err = 0;
  endtask

  task automatic model_edge(input int c, input int b, input int a, input int k);
    int any, ok, a10;
    any = 0;
    for (int i = 0; i < NB; i++) any |= m_open[i];
    a10 = (a >> 10) & 1;
    ok = 0;
    if (m_pwr == 3) ok = (c == 0 || c == 7);
    else if (m_pwr != 0 || k == 0) ok = (c == 0);
    else case (c)
      0: ok = 1;
      1: ok = !m_open[b];
      2, 3: ok = m_open[b] && m_apc[b] == 0;
      4: ok = 1;
      5, 6: ok = !any;
      8: ok = !any && ((b == 0 && half_of(a & 7) != 0) || b == 2);
      9: ok = m_bcnt > 0 && !m_bap;
      default: ok = 0;
    endcase
    m_err = (!ok && c != 0);
    for (int i = 0; i < NB; i++) begin
      if (m_apc[i] == 1) begin m_open[i] = 0; m_apc[i] = 0; end
      else if (m_apc[i] > 0) m_apc[i]--;
    end
    if (ok) begin
      if (c == 4) begin
        for (int i = 0; i < NB; i++)
          if (a10 || i == b) begin m_open[i] = 0; m_apc[i] = 0; end
      end
      if (c == 1) begin m_open[b] = 1; m_row[b] = a; end
      if ((c == 2 || c == 3) && a10) m_apc[b] = m_half;
    end
    if (ok && (c == 2 || c == 3)) begin m_bcnt = m_half; m_bap = a10; end
    else if (ok && c == 9) m_bcnt = 0;
    else if (m_bcnt > 0) m_bcnt--;
    if (m_pwr == 0) begin
      if (ok && c == 6) m_pwr = 3;
      else if (k == 0) m_pwr = any ? 2 : 1;
    end else if (m_pwr == 3) begin
      if (ok && c == 7) m_pwr = 0;
    end else if (k) m_pwr = 0;
    if (ok && c == 8 && b == 0) m_half = half_of(a & 7);
  endtask

  task automatic compare(input string tag);
    int any, emode;
    logic [NB-1:0] eopen;
    logic [NB*RW-1:0] erow;
    any = 0;
    for (int i = 0; i < NB; i++) begin
      eopen[i] = m_open[i][0];
      erow[i*RW +: RW] = m_row[i][RW-1:0];
      any |= m_open[i];
    end
    case (m_pwr)
      0: emode = any ? 1 : 0;
      1: emode = 2;
      2: emode = 3;
      default: emode = 4;
    endcase
    checks++;
    if (bank_open !== eopen || open_row !== erow || mode !== 3'(emode) ||
        burst_busy !== (m_bcnt > 0) || cmd_err !== m_err[0]) begin
      errors++;
      $display("FAIL %s: open=%b row=%h mode=%0d busy=%b err=%b expected open=%b row=%h mode=%0d busy=%0d err=%0d",
               tag, bank_open, open_row, mode, burst_busy, cmd_err,
               eopen, erow, emode, m_bcnt > 0, m_err);
    end
  endtask

  task automatic step(input int c, input int b, input int a, input int k, input string tag);
    cmd = 4'(c); ba = 2'(b); addr = RW'(a); cke = k[0];
    @(posedge clk);
    model_edge(c, b, a, k);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd = 0; ba = 0; addr = 0; cke = 1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    compare("R1 reset");
    // R2 activates
    step(1, 0, 'h1ABC, 1, "R2 act b0");
    step(1, 2, 'h0123, 1, "R2 act b2");
    // R3 illegal bank access
    step(2, 1, 0, 1, "R3 rd idle bank");
    step(1, 0, 'h0555, 1, "R3 act open bank");
    step(3, 3, 0, 1, "R3 wr idle bank");
    idle(1, "R3 pulse ends R13");
    // R6 bursts and restart
    step(2, 0, 'h0010, 1, "R6 rd b0");
    idle(3, "R6 burst drain");
    step(3, 2, 0, 1, "R6 wr b2");
    step(2, 0, 0, 1, "R6 restart");
    idle(3, "R6 drain");
    // R7 burst stop
    step(2, 2, 0, 1, "R7 rd");
    step(9, 0, 0, 1, "R7 bst");
    step(9, 0, 0, 1, "R7 bst no burst");
    // R4 precharge scopes
    step(4, 3, 0, 1, "R4 pre idle bank");
    step(4, 0, 0, 1, "R4 pre b0 only");
    step(1, 1, 'h0777, 1, "R4 act b1");
    step(4, 0, 'h400, 1, "R4 pre all");
    // R8 global commands
    step(1, 3, 'h0042, 1, "R8 act b3");
    step(5, 0, 0, 1, "R8 ref with open");
    step(8, 0, 3, 1, "R8 lmr with open");
    step(6, 0, 0, 1, "R8 sref with open");
    step(4, 0, 'h400, 1, "R8 pre all");
    step(5, 0, 0, 1, "R8 ref idle");
    // R9 mode loads
    step(8, 0, 0, 1, "R9 reserved code");
    step(8, 1, 2, 1, "R9 bank1");
    step(8, 2, 'h067, 1, "R9 extended");
    step(8, 0, 3, 1, "R9 bl8");
    // R5 auto-precharge at BL8
    step(1, 3, 'h0ABC, 1, "R5 act b3");
    step(2, 3, 'h400, 1, "R5 rd ap");
    step(9, 0, 0, 1, "R7 bst ap burst");
    step(3, 3, 0, 1, "R5 wr pending");
    step(1, 3, 0, 1, "R5 act pending");
    idle(3, "R5 close wait");
    step(8, 0, 1, 1, "R9 bl2");
    step(1, 1, 'h1111, 1, "R5 act b1");
    step(3, 1, 'h400, 1, "R5 wr ap bl2");
    idle(2, "R5 close bl2");
    step(8, 0, 4, 1, "R9 bl16");
    step(1, 0, 'h0F0F, 1, "R6 act");
    step(2, 0, 0, 1, "R6 bl16");
    idle(9, "R6 bl16 drain");
    step(4, 0, 'h400, 1, "R4 pre all");
    // R10 / R11 power-down
    step(0, 0, 0, 0, "R10 ppd entry");
    step(1, 2, 5, 0, "R11 act cke low");
    step(0, 0, 0, 1, "R10 exit");
    step(1, 2, 'h0333, 1, "R10 act");
    step(0, 0, 0, 0, "R10 apd entry");
    step(4, 2, 0, 1, "R11 pre during pd");
    idle(1, "R10 back to run");
    step(4, 2, 0, 1, "R4 pre b2");
    // R11 self refresh
    step(6, 0, 0, 1, "R11 sr entry");
    step(1, 0, 1, 1, "R11 act in sr");
    step(0, 0, 0, 0, "R11 cke ignored sr");
    step(7, 0, 0, 1, "R11 sr exit");
    step(7, 0, 0, 1, "R12 srout in run");
    step(15, 0, 0, 1, "R12 undefined");
    step(10, 1, 0, 1, "R12 undefined 10");
    idle(2, "R13 quiet");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule